// File: doc/BRIEF.md
# Pointer-Table Heap Controller

This block is a small shared-memory heap that sits behind a single valid/ready request port and a single valid/ready response port. A requester sends a transaction as a short series of 16-bit beats. The first beat holds an opcode and the requester's own ID. The second beat names the memory module the transaction is meant for. Any further beats hold operands. The block can allocate a region, read or write one word through a virtual pointer, free a region, or take and drop a per-region lock.

Every live region has a row in a compact table. The row holds the region's virtual base, its size, a type code, a lock flag and the ID of the lock holder. New regions are placed right after the last live row, so a freed gap in the middle is never reused. A pointer anywhere inside a live region is resolved by a containment search. Because the internal store is indexed directly by the virtual address, that search only has to validate the pointer and locate the row. Each operation has its own programmable response delay. Freeing a row closes the gap in the table one row per cycle, and the request port stays closed while this happens.

Top module: `ptr_heap`

## Requirements
- R1: Beat 0 carries the opcode in bits [2:0] (0 allocate, 1 read, 2 write, 3 free, 4 lock, 5 unlock) and the requester ID in bits [4:3]. Beat 1 carries the module ID in bits [1:0]. If the module ID differs from MY_ID (default 1), all of the transaction's beats are still taken, but no response is given and the table is left unchanged. After reset, req_ready is 1 and resp_valid is 0.
- R2: An allocate request (beat 2 size, beat 3 type code) answers with status OK (0) and a virtual pointer. The pointer is 0 when no row is live. Otherwise it is the base of the last live row plus that row's size.
- R3: An allocate request is refused with status 1 and data 0, and no row is created, in any of these cases: the size is zero, the table already holds ENT rows (default 4), the running total plus the size would exceed CAP (default 48), or the region would end past the 2^AW-word store (default 64 words).
- R4: A write (beat 2 pointer, beat 3 data) or a read (beat 2 pointer) succeeds for any pointer p that lies in [base, base+size) of a live row. It reaches store word p. The read returns that word.
- R5: A pointer that lies inside no live row gives status 2. A read then returns data 0, and a write leaves the store untouched. Every response whose status is not 0 carries data 0.
- R6: A free request (beat 2 pointer) succeeds only for the exact base of a live row. It removes the row and subtracts the row's size from the total. Other rows keep their pointers, and the next allocation chains from the last row still live. A pointer that is not a base gives status 2.
- R7: A lock request marks the row holding the pointer as owned by the requester. An unlock request clears the mark. Both return the row's type code. A write, free, lock or unlock from any requester other than the owner gives status 3, while a read is never blocked.
- R8: resp_valid rises exactly LAT+2 clock edges after the edge that takes the last beat. LAT is 1 for allocate, 2 for read, 3 for write, 1 for free and 0 for lock or unlock.
- R9: While resp_valid is 1 and resp_ready is 0, the response stays valid and its status and data do not change.
- R10: After the response handshake of a successful free, req_ready stays 0 for exactly as many cycles as there are live rows above the freed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Block can take a request beat |
| req_data | input | 16 | Request beat |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Requester takes the response |
| resp_status | output | 2 | 0 OK, 1 no space, 2 bad pointer, 3 locked |
| resp_data | output | 16 | Virtual pointer, read word or type code |

## Verification
Every transaction records the edge that takes its last beat. The response is then awaited by sampling on falling edges, and the bench requires resp_valid to appear exactly LAT+2 edges later, using the latency of that opcode. After each handshake the bench counts the falling edges on which req_ready is low and compares the count with the number of rows the free had to shift. For an ignored request, the bench watches the response port for ten cycles and then shows that the table is unchanged through the next allocation's pointer.

// File: rtl/ptr_heap.sv
module ptr_heap #(
  parameter int DW      = 16,
  parameter int AW      = 6,
  parameter int ENT     = 4,
  parameter int TW      = 4,
  parameter int IDW     = 2,
  parameter int MY_ID   = 1,
  parameter int CAP     = 48,
  parameter int L_ALLOC = 1,
  parameter int L_READ  = 2,
  parameter int L_WRITE = 3,
  parameter int L_FREE  = 1,
  parameter int L_LOCK  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_data,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [1:0]    resp_status,
  output logic [DW-1:0] resp_data
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = $clog2(ENT + 1);
  localparam int XW    = (ENT > 1) ? $clog2(ENT) : 1;
  localparam int LW    = 8;

  localparam logic [2:0] OP_ALLOC = 3'd0, OP_RD = 3'd1, OP_WR = 3'd2,
                         OP_FREE = 3'd3, OP_LOCK = 3'd4, OP_UNLK = 3'd5;
  localparam logic [1:0] ST_OK = 2'd0, ST_FULL = 2'd1, ST_BAD = 2'd2, ST_HELD = 2'd3;

  typedef enum logic [2:0] {S_CMD, S_LOOK, S_WAIT, S_RESP, S_PACK} state_t;
  state_t state;

  logic [1:0]     bc_q;
  logic [2:0]     op_q;
  logic [1:0]     src_q;
  logic           mod_ok_q;
  logic [DW-1:0]  f2_q, f3_q;

  logic [DW-1:0]  base_q [ENT];
  logic [DW-1:0]  size_q [ENT];
  logic [TW-1:0]  type_q [ENT];
  logic           rsv_q  [ENT];
  logic [1:0]     own_q  [ENT];

  logic [EW-1:0]  cnt_q, pk_q;
  logic [DW:0]    total_q;
  logic [LW-1:0]  wait_q;
  logic           freed_q;
  logic [1:0]     st_q;
  logic [DW-1:0]  rd_q;

  logic [DW-1:0]  mem [DEPTH];

  logic           hit, held, base_eq, nospace, take, last_beat, wr_en;
  logic [XW-1:0]  hidx, lidx;
  logic [DW+1:0]  end_last, end_new, tot_new;
  logic [1:0]     last_bc;
  logic [LW-1:0]  lat;

  assign req_ready   = (state == S_CMD);
  assign resp_valid  = (state == S_RESP);
  assign resp_status = st_q;
  assign resp_data   = rd_q;

  assign take      = req_valid && req_ready;
  assign last_bc   = (op_q == OP_ALLOC || op_q == OP_WR) ? 2'd3 :
                     (op_q <= OP_UNLK) ? 2'd2 : 2'd1;
  assign last_beat = (bc_q != 2'd0) && (bc_q == last_bc);

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = 0; i < ENT; i++) begin
      if (EW'(i) < cnt_q && {2'b0, f2_q} >= {2'b0, base_q[i]} &&
          {2'b0, f2_q} < {2'b0, base_q[i]} + {2'b0, size_q[i]}) begin
        hit  = 1'b1;
        hidx = XW'(i);
      end
    end
  end

  assign lidx     = XW'(cnt_q - 1'b1);
  assign end_last = (cnt_q == '0) ? '0 : {2'b0, base_q[lidx]} + {2'b0, size_q[lidx]};
  assign end_new  = end_last + {2'b0, f2_q};
  assign tot_new  = {1'b0, total_q} + {2'b0, f2_q};
  assign nospace  = (cnt_q == EW'(ENT)) || (f2_q == '0) ||
                    (tot_new > (DW+2)'(CAP)) || (end_new > (DW+2)'(DEPTH));
  assign held     = rsv_q[hidx] && (own_q[hidx] != src_q);
  assign base_eq  = (f2_q == base_q[hidx]);
  assign wr_en    = (state == S_LOOK) && (op_q == OP_WR) && hit && !held;

  always_comb begin
    case (op_q)
      OP_ALLOC: lat = LW'(L_ALLOC);
      OP_RD:    lat = LW'(L_READ);
      OP_WR:    lat = LW'(L_WRITE);
      OP_FREE:  lat = LW'(L_FREE);
      default:  lat = LW'(L_LOCK);
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[f2_q[AW-1:0]] <= f3_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_CMD;
      bc_q     <= '0;
      op_q     <= '0;
      src_q    <= '0;
      mod_ok_q <= 1'b0;
      f2_q     <= '0;
      f3_q     <= '0;
      cnt_q    <= '0;
      pk_q     <= '0;
      total_q  <= '0;
      wait_q   <= '0;
      freed_q  <= 1'b0;
      st_q     <= ST_OK;
      rd_q     <= '0;
      for (int i = 0; i < ENT; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        type_q[i] <= '0;
        rsv_q[i]  <= 1'b0;
        own_q[i]  <= '0;
      end
    end else begin
      case (state)
        S_CMD: if (take) begin
          case (bc_q)
            2'd0: begin op_q <= req_data[2:0]; src_q <= req_data[4:3]; end
            2'd1: mod_ok_q <= (req_data[IDW-1:0] == IDW'(MY_ID));
            2'd2: f2_q <= req_data;
            default: f3_q <= req_data;
          endcase
          if (last_beat) begin
            bc_q <= '0;
            if (mod_ok_q && op_q <= OP_UNLK) state <= S_LOOK;
          end else begin
            bc_q <= bc_q + 2'd1;
          end
        end
        S_LOOK: begin
          wait_q  <= lat;
          freed_q <= 1'b0;
          st_q    <= ST_OK;
          rd_q    <= '0;
          state   <= S_WAIT;
          case (op_q)
            OP_ALLOC: begin
              if (nospace) st_q <= ST_FULL;
              else begin
                base_q[XW'(cnt_q)] <= end_last[DW-1:0];
                size_q[XW'(cnt_q)] <= f2_q;
                type_q[XW'(cnt_q)] <= f3_q[TW-1:0];
                rsv_q[XW'(cnt_q)]  <= 1'b0;
                own_q[XW'(cnt_q)]  <= '0;
                cnt_q   <= cnt_q + 1'b1;
                total_q <= total_q + {1'b0, f2_q};
                rd_q    <= end_last[DW-1:0];
              end
            end
            OP_RD: begin
              if (!hit) st_q <= ST_BAD;
              else rd_q <= mem[f2_q[AW-1:0]];
            end
            OP_WR: begin
              if (!hit) st_q <= ST_BAD;
              else if (held) st_q <= ST_HELD;
            end
            OP_FREE: begin
              if (!hit || !base_eq) st_q <= ST_BAD;
              else if (held) st_q <= ST_HELD;
              else begin
                total_q     <= total_q - {1'b0, size_q[hidx]};
                cnt_q       <= cnt_q - 1'b1;
                pk_q        <= EW'(hidx);
                freed_q     <= 1'b1;
                rsv_q[hidx] <= 1'b0;
              end
            end
            default: begin
              if (!hit) st_q <= ST_BAD;
              else if (held) st_q <= ST_HELD;
              else begin
                rsv_q[hidx] <= (op_q == OP_LOCK);
                own_q[hidx] <= src_q;
                rd_q        <= {{(DW-TW){1'b0}}, type_q[hidx]};
              end
            end
          endcase
        end
        S_WAIT: begin
          if (wait_q == '0) state <= S_RESP;
          else wait_q <= wait_q - 1'b1;
        end
        S_RESP: if (resp_ready) begin
          state <= (freed_q && pk_q < cnt_q) ? S_PACK : S_CMD;
        end
        S_PACK: begin
          base_q[XW'(pk_q)] <= base_q[XW'(pk_q + 1'b1)];
          size_q[XW'(pk_q)] <= size_q[XW'(pk_q + 1'b1)];
          type_q[XW'(pk_q)] <= type_q[XW'(pk_q + 1'b1)];
          rsv_q[XW'(pk_q)]  <= rsv_q[XW'(pk_q + 1'b1)];
          own_q[XW'(pk_q)]  <= own_q[XW'(pk_q + 1'b1)];
          pk_q <= pk_q + 1'b1;
          if (pk_q + 1'b1 >= cnt_q) state <= S_CMD;
        end
        default: state <= S_CMD;
      endcase
    end
  end
endmodule

// File: rtl/ptr_heap_chk.sv
module ptr_heap_chk #(
  parameter int DW  = 16,
  parameter int ENT = 4,
  parameter int CAP = 48,
  parameter int EW  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          resp_valid,
  input logic          resp_ready,
  input logic [1:0]    resp_status,
  input logic [DW-1:0] resp_data,
  input logic [EW-1:0] cnt_q,
  input logic [DW:0]   total_q
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data) && $stable(resp_status));

  p_total_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    total_q <= (DW+1)'(CAP));

  p_rows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= EW'(ENT));

  p_nonok_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_status != 2'd0 |-> resp_data == '0);

  p_min_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !resp_valid);
endmodule

bind ptr_heap ptr_heap_chk #(.DW(DW), .ENT(ENT), .CAP(CAP), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_status(resp_status),
  .resp_data(resp_data), .cnt_q(cnt_q), .total_q(total_q)
);

// File: tb/sim_ptr_heap.sv
`timescale 1ns/1ps
module sim_ptr_heap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_data = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [1:0]  resp_status;
  logic [15:0] resp_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_acc = 0;

  localparam int LA = 3, LR = 4, LWR = 5, LF = 3, LK = 2;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ptr_heap u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_status(resp_status), .resp_data(resp_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic beat(input logic [15:0] w);
    @(negedge clk);
    req_valid = 1'b1;
    req_data  = w;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 last_acc = cyc;
  endtask

  task automatic send(input logic [2:0] op, input logic [1:0] src, input logic [1:0] md,
                      input logic [15:0] w2, input logic [15:0] w3);
    beat({11'd0, src, op});
    beat({14'd0, md});
    beat(w2);
    if (op == 3'd0 || op == 3'd2) beat(w3);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic xact(input string tag, input logic [2:0] op, input logic [1:0] src,
                      input logic [15:0] w2, input logic [15:0] w3, input int exp_st,
                      input int exp_d, input int exp_lat, input int exp_pack);
    int lat, pack;
    send(op, src, 2'd1, w2, w3);
    while (!resp_valid) @(negedge clk);
    lat = cyc - last_acc;
    check({tag, " status"}, int'(resp_status), exp_st);
    check({tag, " data"}, int'(resp_data), exp_d);
    check({tag, " latency R8"}, lat, exp_lat);
    @(posedge clk);
    pack = 0;
    @(negedge clk);
    while (!req_ready) begin
      pack++;
      @(negedge clk);
    end
    check({tag, " ready gap R10"}, pack, exp_pack);
  endtask

  task automatic t_reset();
    check("R1 reset req_ready", int'(req_ready), 1);
    check("R1 reset resp_valid", int'(resp_valid), 0);
  endtask

  task automatic t_alloc_chain();
    xact("R2 first alloc", 3'd0, 2'd1, 16'd8, 16'd3, 0, 0, LA, 0);
    xact("R2 second alloc", 3'd0, 2'd1, 16'd16, 16'd5, 0, 8, LA, 0);
    xact("R2 third alloc", 3'd0, 2'd1, 16'd8, 16'd7, 0, 24, LA, 0);
  endtask

  task automatic t_wrong_id();
    int seen = 0;
    send(3'd0, 2'd1, 2'd2, 16'd4, 16'd1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (resp_valid) seen++;
    end
    check("R1 no response to other module", seen, 0);
    check("R1 port open after ignored request", int'(req_ready), 1);
  endtask

  task automatic t_capacity();
    xact("R3 over capacity", 3'd0, 2'd1, 16'd17, 16'd1, 1, 0, LA, 0);
    xact("R3 zero size", 3'd0, 2'd1, 16'd0, 16'd1, 1, 0, LA, 0);
    xact("R1 R2 fourth alloc after ignored", 3'd0, 2'd1, 16'd4, 16'd9, 0, 32, LA, 0);
    xact("R3 table full", 3'd0, 2'd1, 16'd1, 16'd1, 1, 0, LA, 0);
  endtask

  task automatic t_access();
    xact("R4 write inner", 3'd2, 2'd1, 16'd10, 16'hBEEF, 0, 0, LWR, 0);
    xact("R4 read inner", 3'd1, 2'd1, 16'd10, 16'd0, 0, 16'hBEEF, LR, 0);
    xact("R4 write base", 3'd2, 2'd1, 16'd0, 16'h1111, 0, 0, LWR, 0);
    xact("R4 write row2", 3'd2, 2'd1, 16'd25, 16'h2525, 0, 0, LWR, 0);
    xact("R4 read base", 3'd1, 2'd1, 16'd0, 16'd0, 0, 16'h1111, LR, 0);
    xact("R5 read past end", 3'd1, 2'd1, 16'd40, 16'd0, 2, 0, LR, 0);
    xact("R5 write past end", 3'd2, 2'd1, 16'd36, 16'hDEAD, 2, 0, LWR, 0);
    xact("R5 read untouched", 3'd1, 2'd1, 16'd36, 16'd0, 2, 0, LR, 0);
  endtask

  task automatic t_lock();
    xact("R7 lock", 3'd4, 2'd1, 16'd12, 16'd0, 0, 5, LK, 0);
    xact("R7 write by other", 3'd2, 2'd2, 16'd12, 16'h7777, 3, 0, LWR, 0);
    xact("R7 read by other", 3'd1, 2'd2, 16'd10, 16'd0, 0, 16'hBEEF, LR, 0);
    xact("R7 free by other", 3'd3, 2'd2, 16'd8, 16'd0, 3, 0, LF, 0);
    xact("R7 write by owner", 3'd2, 2'd1, 16'd12, 16'h1212, 0, 0, LWR, 0);
    xact("R7 read owner write", 3'd1, 2'd2, 16'd12, 16'd0, 0, 16'h1212, LR, 0);
    xact("R7 unlock by other", 3'd5, 2'd2, 16'd12, 16'd0, 3, 0, LK, 0);
    xact("R7 unlock by owner", 3'd5, 2'd1, 16'd12, 16'd0, 0, 5, LK, 0);
  endtask

  task automatic t_free();
    xact("R6 free non-base", 3'd3, 2'd1, 16'd9, 16'd0, 2, 0, LF, 0);
    xact("R6 free middle", 3'd3, 2'd2, 16'd8, 16'd0, 0, 0, LF, 2);
    xact("R6 freed range invalid", 3'd1, 2'd1, 16'd10, 16'd0, 2, 0, LR, 0);
    xact("R6 shifted row kept", 3'd1, 2'd1, 16'd25, 16'd0, 0, 16'h2525, LR, 0);
    xact("R6 first row kept", 3'd1, 2'd1, 16'd0, 16'd0, 0, 16'h1111, LR, 0);
    xact("R6 type after shift", 3'd4, 2'd1, 16'd33, 16'd0, 0, 9, LK, 0);
    xact("R6 unlock after shift", 3'd5, 2'd1, 16'd33, 16'd0, 0, 9, LK, 0);
    xact("R6 chain after free", 3'd0, 2'd1, 16'd8, 16'd2, 0, 36, LA, 0);
    xact("R10 free last row", 3'd3, 2'd1, 16'd36, 16'd0, 0, 0, LF, 0);
  endtask

  task automatic t_hold();
    logic [1:0]  s0;
    logic [15:0] d0;
    int stable = 1;
    resp_ready = 1'b0;
    send(3'd0, 2'd1, 2'd1, 16'd4, 16'd1);
    while (!resp_valid) @(negedge clk);
    check("R8 alloc latency under stall", cyc - last_acc, LA);
    s0 = resp_status;
    d0 = resp_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!resp_valid || resp_status != s0 || resp_data != d0) stable = 0;
    end
    check("R9 response held", stable, 1);
    check("R2 R9 held pointer", int'(d0), 36);
    resp_ready = 1'b1;
    @(negedge clk);
    check("R9 released after ready", int'(resp_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc_chain();
    t_wrong_id();
    t_capacity();
    t_access();
    t_lock();
    t_free();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule